// File: doc/BRIEF.md
# Byte-Interleaved TDM Receive Multiplexer

This block merges the received channel bytes of up to four T1 framers onto one shared serial backplane bus running at 8.192 Mb/s. The bus frame holds 1024 bits, or 128 byte slots. Each framer owns a 7-bit slot offset, and its bytes follow one another every fourth slot from that offset. Alongside the data line, a signaling line carries each framer's signaling bytes in the same slots as the data. A frame-indicator line flags the F-bit of the framer in position 0. Slots that no framer owns carry filler ones.

Every framer loads 26 bytes per frame into its own double-buffered store: byte 0 is the F-bit byte, bytes 1 to 24 are the channels and byte 25 is the parity byte. A common frame pulse, whose polarity can be programmed, aligns the bus. A sampled copy of the bus clock, taken with the fast core clock, supplies the rising and falling bus-clock edges. A 1x mode sends one bit per active edge. A 2x mode spreads each bit over two active edges, and a control picks which of those two edges updates the outputs.

Top module: `tdm_rx_mux`

## Requirements
- R1: After reset, and until the first active frame pulse has been consumed, ser_data and ser_sig stay at 1 and frame_ind stays at its inactive level, which equals fp_inv.
- R2: The frame pulse is sampled only on falling bus-clock edges when fp_fall_sel=1, and only on rising edges when fp_fall_sel=0. It is active when frame_pulse XOR fp_inv is 1. The first output edge at or after an active sample restarts the bus at bit 0, and the banks swap at that point.
- R3: Byte j (0..25) of framer k goes to slot fr_offset[k] + 4*j, and bus bit n belongs to slot n/8. A byte whose slot would exceed 127 is not sent. A slot that no framer owns carries 1 on both serial lines.
- R4: Within a slot, bit position p (n mod 8) carries bit 7-p of the byte, so the MSB goes first.
- R5: ser_sig carries the signaling byte in the same slot and bit order as ser_data.
- R6: frame_ind XOR fp_inv is 1 for exactly bus bit 8*fr_offset[0], and 0 for every other bit.
- R7: In 1x mode (mode_2x=0), each output edge advances one bit. Output edges are rising when out_rise_sel=1 and falling when it is 0. The 1024-bit frame rolls over with no new pulse.
- R8: In 2x mode, each bit spans two output edges. The first edge is the one that starts the bit after sync. Outputs update on the first edge when upd_second=0 and on the second edge when upd_second=1, and hold on the other edge.
- R9: In 2x mode, when fp_fall_sel differs from out_rise_sel, upd_second is ignored and outputs update on the first edge.
- R10: A write (wr_en, wr_addr<26) goes to the bank that is not being shown. The banks swap at every bit-0 start, so bytes written during one frame appear in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Backplane bit clock, sampled by clk |
| frame_pulse | input | 1 | Common frame pulse |
| mode_2x | input | 1 | 1: bus clock runs at twice the bit rate |
| fp_fall_sel | input | 1 | 1: sample the pulse on falling edges |
| out_rise_sel | input | 1 | 1: update the outputs on rising edges |
| upd_second | input | 1 | 2x mode: update on the second edge of a bit |
| fp_inv | input | 1 | Pulse and indicator are active low when 1 |
| fr_offset | input | 28 | Four 7-bit slot offsets, framer 0 in the low bits |
| wr_en | input | 4 | Per-framer byte write strobe |
| wr_addr | input | 20 | Four 5-bit byte indices |
| wr_data | input | 32 | Four channel data bytes |
| wr_sig | input | 32 | Four signaling bytes |
| ser_data | output | 1 | Serial interleaved data |
| ser_sig | output | 1 | Serial signaling, aligned with the data |
| frame_ind | output | 1 | F-bit flag for framer 0 |

## Verification
The bench runs a reference model of the edge rules on every bus-clock transition and compares all three outputs, in both rates and in every pairing of the two edge selects. A design that samples the pulse on the wrong edge, or starts the frame one edge late, shifts the whole stream and fails on the first framer byte. When the edge selects differ in 2x mode, a design that still honours upd_second moves every update by half a bit. An offset set near the top of the frame drops the last bytes; a design that wraps them instead corrupts the low slots. A second pattern, written during the first frame and expected in the second, exposes a design that writes to the shown bank or never swaps.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int NUM_FR_D   = 4;
    localparam int FR_BYTES_D = 26;
    localparam int OFS_W      = 7;
    localparam int CNT_W      = OFS_W + 3;
    localparam logic FILL_BIT = 1'b1;

    typedef logic [CNT_W-1:0] bitpos_t;

    // timing outcome of one core cycle
    typedef struct packed {
        logic    tick;
        logic    upd;
        logic    swap;
        logic    synced;
        bitpos_t bitn;
    } bit_tmg_t;

    // what one framer buffer offers for the current slot
    typedef struct packed {
        logic       hit;
        logic [7:0] data;
        logic [7:0] sig;
    } slot_rd_t;

    function automatic logic [OFS_W-1:0] slot_of(bitpos_t b);
        return b[CNT_W-1:3];
    endfunction

    function automatic logic [2:0] lane_of(bitpos_t b);
        return 3'd7 - b[2:0];
    endfunction

endpackage

// File: rtl/tdm_edge_sel.sv
module tdm_edge_sel (
    input  logic clk,
    input  logic rst,
    input  logic bus_clk,
    input  logic fp_fall_sel,
    input  logic out_rise_sel,
    output logic fp_ev,
    output logic out_ev
);
    logic bck_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) bck_q <= 1'b0;
        else     bck_q <= bus_clk;
    end

    always_comb begin
        rise   = bus_clk & ~bck_q;
        fall   = ~bus_clk & bck_q;
        fp_ev  = fp_fall_sel ? fall : rise;
        out_ev = out_rise_sel ? rise : fall;
    end

endmodule

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer
    import tdm_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fp_ev,
    input  logic     out_ev,
    input  logic     frame_pulse,
    input  logic     fp_inv,
    input  logic     mode_2x,
    input  logic     upd_second,
    input  logic     fp_fall_sel,
    input  logic     out_rise_sel,
    output bit_tmg_t tmg
);
    logic    synced_q, pend_q, ph_q;
    bitpos_t bit_q;

    logic    fp_hit, sync_now, sec_eff, nph;
    bitpos_t nbit;

    always_comb begin
        fp_hit   = fp_ev & (frame_pulse ^ fp_inv);
        sync_now = fp_hit | pend_q;
        // second-edge choice only counts when both edge selects agree
        sec_eff  = mode_2x & upd_second & (fp_fall_sel == out_rise_sel);
        if (sync_now) begin
            nbit = '0;
            nph  = 1'b0;
        end else if (mode_2x) begin
            nph  = ~ph_q;
            nbit = ph_q ? bitpos_t'(bit_q + 1'b1) : bit_q;
        end else begin
            nph  = 1'b0;
            nbit = bitpos_t'(bit_q + 1'b1);
        end
        tmg.tick   = out_ev & (synced_q | sync_now);
        tmg.upd    = tmg.tick & (nph == sec_eff);
        tmg.swap   = tmg.tick & (nbit == '0) & ~nph;
        tmg.synced = synced_q;
        tmg.bitn   = nbit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            synced_q <= 1'b0;
            pend_q   <= 1'b0;
            ph_q     <= 1'b0;
            bit_q    <= '0;
        end else begin
            if (tmg.tick) begin
                bit_q    <= nbit;
                ph_q     <= nph;
                synced_q <= 1'b1;
            end
            if (out_ev)      pend_q <= 1'b0;
            else if (fp_hit) pend_q <= 1'b1;
        end
    end

    // R2
    sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
        out_ev && fp_hit |=> bit_q == '0 && ph_q == 1'b0);

    // R7
    one_x_step_chk: assert property (@(posedge clk) disable iff (rst)
        tmg.tick && !mode_2x && !sync_now |=> bit_q == bitpos_t'($past(bit_q) + 1'b1));

    // R8
    two_x_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tmg.tick && mode_2x && !sync_now && !ph_q |=> bit_q == $past(bit_q) && ph_q);

endmodule

// File: rtl/tdm_chan_buf.sv
module tdm_chan_buf
    import tdm_rx_pkg::*;
#(
    parameter int FR_BYTES = FR_BYTES_D,
    parameter int STRIDE   = NUM_FR_D,
    localparam int ADDR_W  = $clog2(FR_BYTES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        wr_sig,
    input  logic              wr_bank,
    input  logic              rd_bank,
    input  logic [OFS_W-1:0]  offset,
    input  logic [OFS_W-1:0]  slot,
    output slot_rd_t          rd
);
    localparam int DW = OFS_W + 1;

    logic [7:0] dmem [2][FR_BYTES];
    logic [7:0] smem [2][FR_BYTES];

    logic [DW-1:0]     diff, step;
    logic [ADDR_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (wr_en && int'(wr_addr) < FR_BYTES) begin
            dmem[wr_bank][wr_addr] <= wr_data;
            smem[wr_bank][wr_addr] <= wr_sig;
        end
    end

    always_comb begin
        diff   = {1'b0, slot} - {1'b0, offset};
        step   = diff / DW'(STRIDE);
        idx    = step[ADDR_W-1:0];
        rd.hit = ~diff[DW-1] && ((diff % DW'(STRIDE)) == '0) && (step < DW'(FR_BYTES));
        if (rd.hit) begin
            rd.data = dmem[rd_bank][idx];
            rd.sig  = smem[rd_bank][idx];
        end else begin
            rd.data = '0;
            rd.sig  = '0;
        end
    end

endmodule

// File: rtl/tdm_bus_out.sv
module tdm_bus_out
    import tdm_rx_pkg::*;
#(
    parameter int NUM_FR = NUM_FR_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             upd,
    input  bitpos_t          bitn,
    input  logic [OFS_W-1:0] first_ofs,
    input  slot_rd_t         rd [NUM_FR],
    output logic             sd_q,
    output logic             sig_q,
    output logic             fi_q
);
    logic [NUM_FR-1:0] hit_vec;
    logic              d_nxt, s_nxt, f_nxt;
    logic [2:0]        lane;

    always_comb begin
        lane  = lane_of(bitn);
        d_nxt = FILL_BIT;
        s_nxt = FILL_BIT;
        for (int k = NUM_FR - 1; k >= 0; k--) begin
            hit_vec[k] = rd[k].hit;
            if (rd[k].hit) begin
                d_nxt = rd[k].data[lane];
                s_nxt = rd[k].sig[lane];
            end
        end
        f_nxt = (bitn == {first_ofs, 3'b000});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_q  <= FILL_BIT;
            sig_q <= FILL_BIT;
            fi_q  <= 1'b0;
        end else if (upd) begin
            sd_q  <= d_nxt;
            sig_q <= s_nxt;
            fi_q  <= f_nxt;
        end
    end

    // R3
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> $onehot0(hit_vec));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(sd_q) && $stable(sig_q) && $stable(fi_q));

endmodule

// File: rtl/tdm_rx_mux.sv
module tdm_rx_mux
    import tdm_rx_pkg::*;
#(
    parameter int NUM_FR   = NUM_FR_D,
    parameter int FR_BYTES = FR_BYTES_D,
    localparam int ADDR_W  = $clog2(FR_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_clk,
    input  logic                     frame_pulse,
    input  logic                     mode_2x,
    input  logic                     fp_fall_sel,
    input  logic                     out_rise_sel,
    input  logic                     upd_second,
    input  logic                     fp_inv,
    input  logic [NUM_FR*OFS_W-1:0]  fr_offset,
    input  logic [NUM_FR-1:0]        wr_en,
    input  logic [NUM_FR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_FR*8-1:0]      wr_data,
    input  logic [NUM_FR*8-1:0]      wr_sig,
    output logic                     ser_data,
    output logic                     ser_sig,
    output logic                     frame_ind
);
    logic     fp_ev, out_ev;
    bit_tmg_t tmg;
    logic     bank_q, rd_sel;
    logic     fi_act;
    slot_rd_t rd [NUM_FR];

    tdm_edge_sel edge_i (
        .clk         (clk),
        .rst         (rst),
        .bus_clk     (bus_clk),
        .fp_fall_sel (fp_fall_sel),
        .out_rise_sel(out_rise_sel),
        .fp_ev       (fp_ev),
        .out_ev      (out_ev)
    );

    tdm_bit_timer timer_i (
        .clk         (clk),
        .rst         (rst),
        .fp_ev       (fp_ev),
        .out_ev      (out_ev),
        .frame_pulse (frame_pulse),
        .fp_inv      (fp_inv),
        .mode_2x     (mode_2x),
        .upd_second  (upd_second),
        .fp_fall_sel (fp_fall_sel),
        .out_rise_sel(out_rise_sel),
        .tmg         (tmg)
    );

    // shown bank; flips at each frame start
    always_ff @(posedge clk) begin
        if (rst)           bank_q <= 1'b0;
        else if (tmg.swap) bank_q <= ~bank_q;
    end
    assign rd_sel = tmg.swap ? ~bank_q : bank_q;

    for (genvar k = 0; k < NUM_FR; k++) begin : g_fr
        tdm_chan_buf #(.FR_BYTES(FR_BYTES), .STRIDE(NUM_FR)) buf_i (
            .clk    (clk),
            .wr_en  (wr_en[k]),
            .wr_addr(wr_addr[k*ADDR_W +: ADDR_W]),
            .wr_data(wr_data[k*8 +: 8]),
            .wr_sig (wr_sig[k*8 +: 8]),
            .wr_bank(~bank_q),
            .rd_bank(rd_sel),
            .offset (fr_offset[k*OFS_W +: OFS_W]),
            .slot   (slot_of(tmg.bitn)),
            .rd     (rd[k])
        );
    end

    tdm_bus_out #(.NUM_FR(NUM_FR)) out_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tmg.tick),
        .upd      (tmg.upd),
        .bitn     (tmg.bitn),
        .first_ofs(fr_offset[OFS_W-1:0]),
        .rd       (rd),
        .sd_q     (ser_data),
        .sig_q    (ser_sig),
        .fi_q     (fi_act)
    );

    assign frame_ind = fi_act ^ fp_inv;

    // R1
    idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
        !tmg.synced |-> ser_data == FILL_BIT && ser_sig == FILL_BIT && !fi_act);

    // R10
    swap_flip_chk: assert property (@(posedge clk) disable iff (rst)
        tmg.swap |=> bank_q != $past(bank_q));

endmodule

// File: tb/tdm_rx_mux_tb_top.sv
module tdm_rx_mux_tb_top;
    localparam int NF = 4;
    localparam int NB = 26;
    localparam int AW = 5;
    localparam int NCFG = 12;

    // {mode_2x, fp_fall_sel, out_rise_sel, upd_second, fp_inv, ofs_set[1:0]}
    localparam logic [6:0] CFG [NCFG] = '{
        7'b0_0_1_0_0_00, 7'b0_1_0_0_1_01, 7'b0_0_0_0_0_10, 7'b0_1_1_1_1_00,
        7'b1_0_0_0_0_00, 7'b1_0_0_1_0_01, 7'b1_1_1_0_1_10, 7'b1_1_1_1_0_00,
        7'b1_0_1_1_0_00, 7'b1_1_0_1_1_10, 7'b1_0_1_0_1_01, 7'b1_1_0_0_0_00
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck = 1'b0;
    logic fp = 1'b0;
    logic m2x = 1'b0, fpf = 1'b0, orise = 1'b1, usec = 1'b0, finv = 1'b0;
    logic [NF*7-1:0]  ofs_v = '0;
    logic [NF-1:0]    wen = '0;
    logic [NF*AW-1:0] wad = '0;
    logic [NF*8-1:0]  wdt = '0;
    logic [NF*8-1:0]  wsg = '0;
    logic sd, sg, fi;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tdm_rx_mux dut_i (
        .clk(clk), .rst(rst), .bus_clk(bck), .frame_pulse(fp),
        .mode_2x(m2x), .fp_fall_sel(fpf), .out_rise_sel(orise),
        .upd_second(usec), .fp_inv(finv), .fr_offset(ofs_v),
        .wr_en(wen), .wr_addr(wad), .wr_data(wdt), .wr_sig(wsg),
        .ser_data(sd), .ser_sig(sg), .frame_ind(fi)
    );

    function automatic int ofs_of(int set, int k);
        if (set == 0) return k;
        if (set == 1) return 5 + k;
        return 28 + ((k + 1) % 4);
    endfunction

    function automatic logic [7:0] pat(bit b_pat, int k, int j, bit is_sig);
        logic [7:0] v;
        v = {k[1:0], 1'b0, j[4:0]};
        if (b_pat) v = ~v;
        if (is_sig) v = v ^ 8'h5A;
        return v;
    endfunction

    // {fi_active, data, sig} expected for bus bit n
    function automatic logic [2:0] exp_out(int n, bit b_pat, int set);
        int slot, p, o;
        logic d, s;
        slot = n / 8;
        p = n % 8;
        d = 1'b1;
        s = 1'b1;
        for (int k = 0; k < NF; k++) begin
            o = ofs_of(set, k);
            if (slot >= o && (slot - o) % 4 == 0 && (slot - o) / 4 < NB) begin
                d = pat(b_pat, k, (slot - o) / 4, 1'b0)[7 - p];
                s = pat(b_pat, k, (slot - o) / 4, 1'b1)[7 - p];
            end
        end
        return {(n == 8 * ofs_of(set, 0)), d, s};
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %b want %b", tag, act, exp);
        end
    endtask

    task automatic load_all(bit b_pat);
        for (int j = 0; j < NB; j++) begin
            @(negedge clk);
            wen = '1;
            for (int k = 0; k < NF; k++) begin
                wad[k*AW +: AW] = AW'(j);
                wdt[k*8 +: 8] = pat(b_pat, k, j, 1'b0);
                wsg[k*8 +: 8] = pat(b_pat, k, j, 1'b1);
            end
        end
        @(negedge clk);
        wen = '0;
    endtask

    task automatic run_cfg(int ci);
        logic [6:0] c;
        int set, swaps, wj, mbit, nbit;
        bit msync, mpend, mph, nph, fp_done, drive_fp, rising, sec_eff, ign, isout, sn;
        logic esd, esg, efi;
        logic [2:0] e;
        string tag;
        c = CFG[ci];
        m2x = c[6]; fpf = c[5]; orise = c[4]; usec = c[3]; finv = c[2];
        set = int'(c[1:0]);
        for (int k = 0; k < NF; k++) ofs_v[k*7 +: 7] = 7'(ofs_of(set, k));
        ign = m2x && (fpf != orise);
        sec_eff = m2x && usec && (fpf == orise);
        @(negedge clk);
        rst = 1'b1; bck = 1'b0; fp = finv; wen = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset data", sd, 1'b1);
        chk("R1 reset sig", sg, 1'b1);
        chk("R1 reset ind", fi, finv);
        load_all(1'b0);
        // R1 bus clock running, no pulse yet
        for (int t = 0; t < 6; t++) begin
            bck = ~bck;
            @(negedge clk);
        end
        chk("R1 idle data", sd, 1'b1);
        chk("R1 idle sig", sg, 1'b1);
        chk("R1 idle ind", fi, finv);
        msync = 0; mpend = 0; mph = 0; mbit = 0; swaps = 0; wj = 0; fp_done = 0;
        esd = 1'b1; esg = 1'b1; efi = 1'b0;
        while (swaps < 3) begin
            rising = !bck;
            drive_fp = !fp_done && (rising == !fpf);
            if (drive_fp) fp_done = 1;
            fp = drive_fp ? ~finv : finv;
            if (swaps == 1 && wj < NB) begin
                wen = '1;
                for (int k = 0; k < NF; k++) begin
                    wad[k*AW +: AW] = AW'(wj);
                    wdt[k*8 +: 8] = pat(1'b1, k, wj, 1'b0);
                    wsg[k*8 +: 8] = pat(1'b1, k, wj, 1'b1);
                end
                wj++;
            end else begin
                wen = '0;
            end
            bck = ~bck;
            isout = (rising == orise);
            if (isout) begin
                sn = drive_fp || mpend;
                if (msync || sn) begin
                    if (sn) begin
                        nbit = 0; nph = 0;
                    end else if (m2x) begin
                        nph = !mph;
                        nbit = mph ? (mbit + 1) % 1024 : mbit;
                    end else begin
                        nph = 0;
                        nbit = (mbit + 1) % 1024;
                    end
                    if (nbit == 0 && !nph) swaps++;
                    if (nph == sec_eff) begin
                        e = exp_out(nbit, (swaps % 2) == 0, set);
                        efi = e[2]; esd = e[1]; esg = e[0];
                    end
                    mbit = nbit; mph = nph; msync = 1;
                end
                mpend = 0;
            end else if (drive_fp) begin
                mpend = 1;
            end
            @(negedge clk);
            tag = $sformatf("cfg%0d bit%0d %s%sR3 R4", ci, mbit,
                            (swaps >= 2) ? "R10 " : "R2 ",
                            m2x ? (ign ? "R9 R8 " : "R8 ") : "R7 ");
            chk(tag, sd, esd);
            chk($sformatf("R5 cfg%0d bit%0d sig", ci, mbit), sg, esg);
            chk($sformatf("R6 cfg%0d bit%0d ind", ci, mbit), fi, efi ^ finv);
        end
        wen = '0;
        fp = finv;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int ci = 0; ci < NCFG; ci++) run_cfg(ci);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule